// File: doc/BRIEF.md
# Request/Reply Class-Separated Receive Buffer

This block sits on the receive side of a node's network interface in a system of `NODES` nodes that talk by request/response transactions. Every arriving transaction carries a class bit (request or reply), the identifier of the node that sent it, and a payload. The two classes are stored in physically separate queues. Replies therefore keep draining toward the local processor even when the request class is completely blocked. The input port never stalls. When a request cannot be taken, it is dropped and a refusal (NACK) addressed to its sender is raised for one cycle.

Storage is sized from two parameters: the node count and the bound `MAX_OUT` on outstanding requests per node. The request queue holds `MAX_OUT*(NODES-1)` entries. Each sending node is also limited to `MAX_OUT` entries in that queue by a per-source credit counter. The reply queue holds exactly `MAX_OUT` entries. A local issue gate keeps the node's own outstanding requests at or below `MAX_OUT`, so every reply this node can provoke already has a reserved slot. As a result, a cycle of requests waiting on replies through full buffers cannot form.

The local processor pulses `issue_req` while `issue_ok` is high to launch a request. It consumes requests and replies through two valid/ready dequeue ports.

Top module: `rx_class_buffer`

## Requirements
- R1: After reset, `in_ready` is 0. From the first clock edge with reset low, it is 1 in every cycle, whatever the queue state.
- R2: An arriving reply (`in_is_reply`=1) is never refused. In the cycle after it arrives, `nack_valid` is 0. Replies leave the reply dequeue port in arrival order, with source and data unchanged.
- R3: A request (`in_is_reply`=0) is stored when both of these hold: its source holds fewer than `MAX_OUT` entries in the request queue, and the request queue holds fewer than `MAX_OUT*(NODES-1)` entries. Stored requests leave the request dequeue port in arrival order, with source and data unchanged.
- R4: A request whose source already holds `MAX_OUT` queued entries is not stored. One cycle later, `nack_valid` is 1 for exactly one cycle and `nack_dst` equals that source.
- R5: When the request queue holds `MAX_OUT*(NODES-1)` entries, a further request is refused with a NACK, even if its source has credit left and the reply queue is empty. Reply slots are never used for requests.
- R6: While the request queue is full, replies are still accepted and can be dequeued.
- R7: `issue_ok` is 1 while the number of outstanding local requests is below `MAX_OUT`. An `issue_req` pulse with `issue_ok`=1 adds one outstanding request. Each reply dequeue removes one. An `issue_req` pulse with `issue_ok`=0 has no effect.
- R8: After reset, both dequeue ports show valid=0, `nack_valid` is 0 and `issue_ok` is 1.
- R9: Dequeuing a request returns one credit to its source. After the request queue drains, every source can again have `MAX_OUT` requests accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Network transaction present |
| in_is_reply | input | 1 | 1 = reply class, 0 = request class |
| in_src | input | ID_W | Sending node identifier |
| in_data | input | DATA_W | Payload |
| in_ready | output | 1 | Always-accept indication (registered) |
| req_deq_valid | output | 1 | Request queue not empty |
| req_deq_src | output | ID_W | Source of head request |
| req_deq_data | output | DATA_W | Payload of head request |
| req_deq_ready | input | 1 | Processor takes head request |
| rsp_deq_valid | output | 1 | Reply queue not empty |
| rsp_deq_src | output | ID_W | Source of head reply |
| rsp_deq_data | output | DATA_W | Payload of head reply |
| rsp_deq_ready | input | 1 | Processor takes head reply |
| issue_req | input | 1 | Local request launch pulse |
| issue_ok | output | 1 | Local request may be launched |
| nack_valid | output | 1 | Refusal of a request, one cycle |
| nack_dst | output | ID_W | Node the refusal is addressed to |

## Verification
The hardest condition to reach is the one in R5. The request queue must be full while the sender of the next request still has credit and the reply queue is empty. Per-source credits stop any single source from filling the queue, so this state only appears when the sources collectively reach capacity. The bench gets there by walking through the sources in turn and pushing each one to its credit limit, which also checks the per-source NACK. Once all but one source are exhausted and the queue is full, the last source sends a request that must be refused. Replies are then injected into that full state, and an ignored issue pulse is checked by watching `issue_ok` across a later reply dequeue.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic {
    CLS_REQ = 1'b0,
    CLS_RSP = 1'b1
  } msg_class_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int unsigned PW = rx_pkg::idx_width(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && (cnt != LVL_MAX);
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == LVL_MAX);
  assign level = cnt;
endmodule

// File: rtl/rx_credit_table.sv
module rx_credit_table #(
  parameter int unsigned NODES = 4,
  parameter int unsigned LIMIT = 2,
  parameter int unsigned ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [ID_W-1:0]  take_id,
  input  logic             give,
  input  logic [ID_W-1:0]  give_id,
  output logic [NODES-1:0] has_credit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

  for (genvar n = 0; n < NODES; n++) begin : g_src
    logic [CW-1:0] held;
    logic          inc, dec;
    assign inc = take && (take_id == ID_W'(n));
    assign dec = give && (give_id == ID_W'(n));

    always_ff @(posedge clk) begin
      if (rst) begin
        held <= '0;
      end else begin
        case ({inc, dec})
          2'b10:   held <= held + 1'b1;
          2'b01:   held <= held - 1'b1;
          default: held <= held;
        endcase
      end
    end

    assign has_credit[n] = (held != CNT_MAX);
  end
endmodule

// File: rtl/rx_issue_gate.sv
module rx_issue_gate #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic issue_req,
  input  logic reply_done,
  output logic issue_ok
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

  logic [CW-1:0] outstanding, next_cnt;
  logic          grant, retire;

  assign grant  = issue_req && issue_ok;
  assign retire = reply_done && (outstanding != '0);

  always_comb begin
    next_cnt = outstanding;
    if (grant && !retire)      next_cnt = outstanding + 1'b1;
    else if (retire && !grant) next_cnt = outstanding - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= '0;
      issue_ok    <= 1'b1;
    end else begin
      outstanding <= next_cnt;
      issue_ok    <= (next_cnt != CNT_MAX);
    end
  end
endmodule

// File: rtl/rx_class_buffer.sv
module rx_class_buffer #(
  parameter int unsigned NODES   = 4,
  parameter int unsigned MAX_OUT = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ID_W    = rx_pkg::idx_width(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_reply,
  input  logic [ID_W-1:0]   in_src,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              req_deq_valid,
  output logic [ID_W-1:0]   req_deq_src,
  output logic [DATA_W-1:0] req_deq_data,
  input  logic              req_deq_ready,
  output logic              rsp_deq_valid,
  output logic [ID_W-1:0]   rsp_deq_src,
  output logic [DATA_W-1:0] rsp_deq_data,
  input  logic              rsp_deq_ready,
  input  logic              issue_req,
  output logic              issue_ok,
  output logic              nack_valid,
  output logic [ID_W-1:0]   nack_dst
);
  import rx_pkg::*;

  localparam int unsigned REQ_DEPTH = MAX_OUT * (NODES - 1);
  localparam int unsigned RSP_DEPTH = MAX_OUT;
  localparam int unsigned ENT_W     = ID_W + DATA_W;

  msg_class_e              in_cls;
  logic [NODES-1:0]        credit_ok;
  logic                    req_full, req_empty, rsp_full, rsp_empty;
  logic                    req_push, req_pop, rsp_push, rsp_pop, refuse;
  logic [ENT_W-1:0]        req_head, rsp_head;
  logic [$clog2(REQ_DEPTH+1)-1:0] req_level;
  logic [$clog2(RSP_DEPTH+1)-1:0] rsp_level;

  assign in_cls   = msg_class_e'(in_is_reply);
  assign req_push = in_valid && (in_cls == CLS_REQ) && credit_ok[in_src] && !req_full;
  assign refuse   = in_valid && (in_cls == CLS_REQ) && !req_push;
  assign rsp_push = in_valid && (in_cls == CLS_RSP) && !rsp_full;
  assign req_pop  = req_deq_ready && !req_empty;
  assign rsp_pop  = rsp_deq_ready && !rsp_empty;

  rx_fifo #(.DEPTH(REQ_DEPTH), .WIDTH(ENT_W)) u_req_q (
    .clk(clk), .rst(rst), .push(req_push), .din({in_src, in_data}),
    .pop(req_pop), .dout(req_head), .empty(req_empty), .full(req_full),
    .level(req_level)
  );

  rx_fifo #(.DEPTH(RSP_DEPTH), .WIDTH(ENT_W)) u_rsp_q (
    .clk(clk), .rst(rst), .push(rsp_push), .din({in_src, in_data}),
    .pop(rsp_pop), .dout(rsp_head), .empty(rsp_empty), .full(rsp_full),
    .level(rsp_level)
  );

  rx_credit_table #(.NODES(NODES), .LIMIT(MAX_OUT), .ID_W(ID_W)) u_credit (
    .clk(clk), .rst(rst), .take(req_push), .take_id(in_src),
    .give(req_pop), .give_id(req_head[ENT_W-1 -: ID_W]),
    .has_credit(credit_ok)
  );

  rx_issue_gate #(.LIMIT(MAX_OUT)) u_gate (
    .clk(clk), .rst(rst), .issue_req(issue_req), .reply_done(rsp_pop),
    .issue_ok(issue_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready   <= 1'b0;
      nack_valid <= 1'b0;
      nack_dst   <= '0;
    end else begin
      in_ready   <= 1'b1;
      nack_valid <= refuse;
      if (refuse) nack_dst <= in_src;
    end
  end

  assign req_deq_valid = !req_empty;
  assign req_deq_src   = req_head[ENT_W-1 -: ID_W];
  assign req_deq_data  = req_head[DATA_W-1:0];
  assign rsp_deq_valid = !rsp_empty;
  assign rsp_deq_src   = rsp_head[ENT_W-1 -: ID_W];
  assign rsp_deq_data  = rsp_head[DATA_W-1:0];
endmodule

// File: rtl/rx_class_buffer_chk.sv
module rx_class_buffer_chk #(
  parameter int unsigned NODES   = 4,
  parameter int unsigned MAX_OUT = 2,
  parameter int unsigned LW_REQ  = 3,
  parameter int unsigned LW_RSP  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_is_reply,
  input logic              in_ready,
  input logic              nack_valid,
  input logic              issue_ok,
  input logic              rsp_deq_valid,
  input logic              rsp_deq_ready,
  input logic [LW_REQ-1:0] req_level,
  input logic [LW_RSP-1:0] rsp_level
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);

  assert_reply_no_nack_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_is_reply) |=> !nack_valid);

  assert_nack_cause_R4: assert property (@(posedge clk) disable iff (rst)
    nack_valid |-> $past(in_valid && !in_is_reply));

  assert_req_bound_R5: assert property (@(posedge clk) disable iff (rst)
    req_level <= LW_REQ'(MAX_OUT * (NODES - 1)));

  assert_rsp_bound_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_level <= LW_RSP'(MAX_OUT));

  assert_issue_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!issue_ok && !(rsp_deq_valid && rsp_deq_ready)) |=> !issue_ok);
endmodule

bind rx_class_buffer rx_class_buffer_chk #(
  .NODES(NODES), .MAX_OUT(MAX_OUT),
  .LW_REQ($clog2(MAX_OUT*(NODES-1)+1)), .LW_RSP($clog2(MAX_OUT+1))
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_reply(in_is_reply),
  .in_ready(in_ready), .nack_valid(nack_valid), .issue_ok(issue_ok),
  .rsp_deq_valid(rsp_deq_valid), .rsp_deq_ready(rsp_deq_ready),
  .req_level(req_level), .rsp_level(rsp_level)
);

// File: tb/test_rx_class_buffer.sv
`timescale 1ns/1ps
module test_rx_class_buffer;
  localparam int P = 4;
  localparam int K = 2;
  localparam int DW = 8;
  localparam int IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_is_reply = 0;
  logic [IW-1:0] in_src = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, req_deq_valid, rsp_deq_valid, issue_ok, nack_valid;
  logic [IW-1:0] req_deq_src, rsp_deq_src, nack_dst;
  logic [DW-1:0] req_deq_data, rsp_deq_data;
  logic req_deq_ready = 0, rsp_deq_ready = 0, issue_req = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rx_class_buffer #(.NODES(P), .MAX_OUT(K), .DATA_W(DW)) i_rx_class_buffer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_reply(in_is_reply),
    .in_src(in_src), .in_data(in_data), .in_ready(in_ready),
    .req_deq_valid(req_deq_valid), .req_deq_src(req_deq_src),
    .req_deq_data(req_deq_data), .req_deq_ready(req_deq_ready),
    .rsp_deq_valid(rsp_deq_valid), .rsp_deq_src(rsp_deq_src),
    .rsp_deq_data(rsp_deq_data), .rsp_deq_ready(rsp_deq_ready),
    .issue_req(issue_req), .issue_ok(issue_ok),
    .nack_valid(nack_valid), .nack_dst(nack_dst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input bit rep, input int src, input int data);
    @(negedge clk);
    in_valid = 1; in_is_reply = rep; in_src = IW'(src); in_data = DW'(data);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pop_req(input int src, input int data);
    @(negedge clk);
    check(req_deq_valid, "R3 req valid", int'(req_deq_valid), 1);
    check(req_deq_src == IW'(src) && req_deq_data == DW'(data), "R3 req order",
          int'({req_deq_src, req_deq_data}), src * 256 + data);
    req_deq_ready = 1;
    @(negedge clk);
    req_deq_ready = 0;
  endtask

  task automatic pop_rsp(input int src, input int data);
    @(negedge clk);
    check(rsp_deq_valid && rsp_deq_src == IW'(src) && rsp_deq_data == DW'(data),
          "R2 rsp order", int'({rsp_deq_valid, rsp_deq_src, rsp_deq_data}),
          1024 + src * 256 + data);
    rsp_deq_ready = 1;
    @(negedge clk);
    rsp_deq_ready = 0;
  endtask

  task automatic issue();
    @(negedge clk);
    issue_req = 1;
    @(negedge clk);
    issue_req = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 0, "R1 ready in reset", int'(in_ready), 0);
    rst = 0;
    @(negedge clk);
    check(in_ready == 1, "R1 ready after reset", int'(in_ready), 1);
    check(!req_deq_valid && !rsp_deq_valid, "R8 queues empty",
          int'({req_deq_valid, rsp_deq_valid}), 0);
    check(!nack_valid, "R8 nack low", int'(nack_valid), 0);
    check(issue_ok, "R8 issue_ok high", int'(issue_ok), 1);

    // Each of sources 0..P-2: K accepted, then one refused by credit (R4)
    for (int s = 0; s < P - 1; s++) begin
      for (int j = 0; j <= K; j++) begin
        send(0, s, s * 16 + j);
        if (j < K)
          check(!nack_valid, "R3 accepted no nack", int'(nack_valid), 0);
        else
          check(nack_valid && nack_dst == IW'(s), "R4 credit nack",
                int'({nack_valid, nack_dst}), 4 + s);
      end
    end
    @(negedge clk);
    check(!nack_valid, "R4 nack one cycle", int'(nack_valid), 0);
    check(in_ready, "R1 ready while full", int'(in_ready), 1);

    // Queue full, last source has credit, reply queue empty (R5)
    check(!rsp_deq_valid, "R5 reply queue empty", int'(rsp_deq_valid), 0);
    send(0, P - 1, 200);
    check(nack_valid && nack_dst == IW'(P - 1), "R5 full-queue nack",
          int'({nack_valid, nack_dst}), 4 + P - 1);

    // Local issue gate (R7)
    issue();
    check(issue_ok, "R7 one outstanding", int'(issue_ok), 1);
    issue();
    check(!issue_ok, "R7 at limit", int'(issue_ok), 0);
    issue();
    check(!issue_ok, "R7 ignored issue", int'(issue_ok), 0);

    // Replies into full request state (R6, R2)
    send(1, 1, 101);
    check(!nack_valid, "R6 reply accepted", int'(nack_valid), 0);
    send(1, 2, 102);
    check(!nack_valid && rsp_deq_valid, "R6 reply present",
          int'({nack_valid, rsp_deq_valid}), 1);
    pop_rsp(1, 101);
    check(issue_ok, "R7 reply dequeue frees one", int'(issue_ok), 1);
    pop_rsp(2, 102);
    check(!rsp_deq_valid, "R2 reply queue drained", int'(rsp_deq_valid), 0);

    // Drain requests in order (R3)
    for (int s = 0; s < P - 1; s++)
      for (int j = 0; j < K; j++)
        pop_req(s, s * 16 + j);
    @(negedge clk);
    check(!req_deq_valid, "R3 request queue drained", int'(req_deq_valid), 0);

    // Credits restored (R9): refill from sources 1..P-1
    for (int s = 1; s < P; s++)
      for (int j = 0; j < K; j++) begin
        send(0, s, 64 + s * 8 + j);
        check(!nack_valid, "R9 credit restored", int'(nack_valid), 0);
      end
    for (int s = 1; s < P; s++)
      for (int j = 0; j < K; j++)
        pop_req(s, 64 + s * 8 + j);
    for (int j = 0; j < K; j++) begin
      send(0, 0, 150 + j);
      check(!nack_valid, "R9 source 0 restored", int'(nack_valid), 0);
    end
    for (int j = 0; j < K; j++)
      pop_req(0, 150 + j);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule